// File: doc/BRIEF.md
# Hysteresis Space-Vector Selector for a Dual Two-Level Inverter

This block closes the current loop of an inverter pair that drives the two ends of a set of open transformer windings. On each sampling strobe it takes signed alpha and beta current errors, the polarity of the three phase currents, and one bit that says whether the upper DC capacitor is higher than the lower one. Each error goes through its own multilevel hysteresis quantizer: seven levels on alpha and five on beta. The phase polarities give one of six current sectors. A single lookup, indexed by sector, capacitor comparison and the two levels, returns a voltage-vector index from 0 to 63.

Some vectors produce the same AC voltage but push charge between the capacitors in opposite directions. The capacitor bit selects between two tables that differ only in which of these redundant vectors they hold. This lets the lookup that tracks the current also keep the lower capacitor voltage equal to the regulated upper one. The six upper-switch gate bits and their complements are registered outputs.

Top module: `svsel_hyst`

## Requirements
- R1: A synchronous reset sets ka = 0, kb = 0, sector = 0 and vec = 0. It also sets gate_hi = 6'b000000 and gate_lo = 6'b111111.
- R2: All outputs keep their values in every cycle where `en` is low. All outputs update together, one clock edge after a cycle with `en` high.
- R3: ka is a signed level in -3..+3 that changes by at most one per strobe. Boundary n (n = 1..3) sits at +thr_an between levels n-1 and n, and at -thr_an between levels -(n-1) and -n. ka rises when err_a exceeds the boundary above it plus hyst/2 (integer half), and saturates at +3.
- R4: ka falls only when err_a is below the boundary beneath it minus hyst/2, and saturates at -3. An error that lies inside the band leaves ka unchanged.
- R5: kb follows the same rules with thr_b1 and thr_b2 and saturates at -2 and +2.
- R6: The sector is decoded from isgn = {phase1, phase2, phase3}, where 1 means a positive current. The codes map as 100→0, 110→1, 010→2, 011→3, 001→4 and 101→5. The codes 000 and 111 keep the previous sector.
- R7: The table with vc_hi_gt = 1 is used when the upper capacitor is higher, and the other table otherwise. At ka = -3, kb = +2 the default tables give vector 27 and vector 13 respectively. At ka = kb = 0 both tables give vector 0.
- R8: By default every sector uses the same pair of tables. Sample entries: (ka = 3, kb = 0) gives vector 2, and (ka = 1, kb = -1) gives vector 3 with vc_hi_gt = 1 and vector 31 with vc_hi_gt = 0.
- R9: gate_hi is {S11, S12, S13, S21, S22, S23} and equals the 6-bit vector index, with S11 as bit 5. gate_lo is always the bitwise complement of gate_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sampling strobe |
| err_a | input | EW | Signed alpha current error |
| err_b | input | EW | Signed beta current error |
| isgn | input | 3 | Phase current polarities, 1 = positive |
| vc_hi_gt | input | 1 | 1 when the upper capacitor voltage exceeds the lower one |
| thr_a1 | input | EW | Alpha boundary 1 magnitude (unsigned) |
| thr_a2 | input | EW | Alpha boundary 2 magnitude (unsigned) |
| thr_a3 | input | EW | Alpha boundary 3 magnitude (unsigned) |
| thr_b1 | input | EW | Beta boundary 1 magnitude (unsigned) |
| thr_b2 | input | EW | Beta boundary 2 magnitude (unsigned) |
| hyst | input | EW | Full hysteresis band width (unsigned) |
| ka | output | 3 | Signed alpha level |
| kb | output | 3 | Signed beta level |
| sector | output | 3 | Current sector 0..5 |
| vec | output | 6 | Selected vector index |
| gate_hi | output | 6 | Upper-switch gate bits |
| gate_lo | output | 6 | Lower-switch gate bits |

## Verification
The corner entries of the tables are the hardest states to reach from the ports. The quantizers move only one level per strobe, so ka = -3 together with kb = +2 needs several strobes with large errors of opposite sign. Once that corner is held, only vc_hi_gt is toggled, so the redundant pair 27/13 is observed without moving the levels. The band edges are reached by walking a level up from reset and then applying errors just inside and just outside the band on each side.

// File: rtl/svsel_hyst.sv
module svsel_hyst #(
  parameter int EW = 16,
  parameter logic [209:0] TAB_HI_S0 = {
    6'd27, 6'd14, 6'd14, 6'd28, 6'd16, 6'd16, 6'd30,
    6'd27, 6'd27, 6'd40, 6'd28, 6'd29, 6'd30, 6'd30,
    6'd11, 6'd35, 6'd35, 6'd0,  6'd36, 6'd36, 6'd2,
    6'd24, 6'd24, 6'd8,  6'd6,  6'd3,  6'd21, 6'd21,
    6'd24, 6'd7,  6'd7,  6'd6,  6'd5,  6'd5,  6'd21},
  parameter logic [209:0] TAB_LO_S0 = {
    6'd13, 6'd14, 6'd14, 6'd15, 6'd16, 6'd16, 6'd18,
    6'd13, 6'd13, 6'd42, 6'd15, 6'd17, 6'd18, 6'd18,
    6'd11, 6'd34, 6'd34, 6'd0,  6'd1,  6'd1,  6'd2,
    6'd9,  6'd9,  6'd23, 6'd22, 6'd31, 6'd4,  6'd4,
    6'd9,  6'd7,  6'd7,  6'd22, 6'd5,  6'd5,  6'd4},
  parameter logic [2519:0] VTAB = {6{TAB_LO_S0, TAB_HI_S0}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [EW-1:0] err_a,
  input  logic signed [EW-1:0] err_b,
  input  logic [2:0]           isgn,
  input  logic                 vc_hi_gt,
  input  logic [EW-1:0]        thr_a1,
  input  logic [EW-1:0]        thr_a2,
  input  logic [EW-1:0]        thr_a3,
  input  logic [EW-1:0]        thr_b1,
  input  logic [EW-1:0]        thr_b2,
  input  logic [EW-1:0]        hyst,
  output logic signed [2:0]    ka,
  output logic signed [2:0]    kb,
  output logic [2:0]           sector,
  output logic [5:0]           vec,
  output logic [5:0]           gate_hi,
  output logic [5:0]           gate_lo
);
  localparam int W2 = EW + 2;
  localparam int NA = 7;
  localparam int NB = 5;
  localparam int NE = NA * NB;
  localparam int VW = 6;
  localparam int BLK = NE * VW;

  typedef logic signed [W2-1:0] wide_t;

  function automatic wide_t pick(input int n, input wide_t t1, input wide_t t2, input wide_t t3);
    case (n)
      1:       pick = t1;
      2:       pick = t2;
      default: pick = t3;
    endcase
  endfunction

  function automatic logic signed [2:0] qstep(input wide_t e, input logic signed [2:0] k,
                                              input int kmax, input wide_t t1, input wide_t t2,
                                              input wide_t t3, input wide_t h);
    int ki;
    wide_t up_b, dn_b;
    ki   = int'(k);
    up_b = (ki >= 0) ? pick(ki + 1, t1, t2, t3) : -pick(-ki, t1, t2, t3);
    dn_b = (ki > 0)  ? pick(ki, t1, t2, t3)     : -pick(1 - ki, t1, t2, t3);
    if (ki < kmax && e > up_b + h)       qstep = k + 3'sd1;
    else if (ki > -kmax && e < dn_b - h) qstep = k - 3'sd1;
    else                                 qstep = k;
  endfunction

  wire wide_t ea = wide_t'(err_a);
  wire wide_t eb = wide_t'(err_b);
  wire wide_t ta1 = wide_t'({2'b00, thr_a1});
  wire wide_t ta2 = wide_t'({2'b00, thr_a2});
  wire wide_t ta3 = wide_t'({2'b00, thr_a3});
  wire wide_t tb1 = wide_t'({2'b00, thr_b1});
  wire wide_t tb2 = wide_t'({2'b00, thr_b2});
  wire wide_t hh  = wide_t'({3'b000, hyst[EW-1:1]});

  wire logic signed [2:0] ka_n = qstep(ea, ka, 3, ta1, ta2, ta3, hh);
  wire logic signed [2:0] kb_n = qstep(eb, kb, 2, tb1, tb2, tb2, hh);

  logic [2:0] sec_n;
  always_comb begin
    case (isgn)
      3'b100:  sec_n = 3'd0;
      3'b110:  sec_n = 3'd1;
      3'b010:  sec_n = 3'd2;
      3'b011:  sec_n = 3'd3;
      3'b001:  sec_n = 3'd4;
      3'b101:  sec_n = 3'd5;
      default: sec_n = sector;
    endcase
  end

  logic [5:0] vec_n;
  always_comb begin
    int ent, blk;
    ent   = (2 - int'(kb_n)) * NA + (int'(ka_n) + 3);
    blk   = int'(sec_n) * 2 + (vc_hi_gt ? 0 : 1);
    vec_n = VTAB[blk * BLK + (NE - 1 - ent) * VW +: VW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ka      <= '0;
      kb      <= '0;
      sector  <= '0;
      vec     <= '0;
      gate_hi <= '0;
      gate_lo <= '1;
    end else if (en) begin
      ka      <= ka_n;
      kb      <= kb_n;
      sector  <= sec_n;
      vec     <= vec_n;
      gate_hi <= vec_n;
      gate_lo <= ~vec_n;
    end
  end
endmodule

// File: rtl/svsel_hyst_chk.sv
module svsel_hyst_chk (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic signed [2:0] ka,
  input logic signed [2:0] kb,
  input logic [2:0]        sector,
  input logic [5:0]        vec,
  input logic [5:0]        gate_hi,
  input logic [5:0]        gate_lo
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (ka == 0 && kb == 0 && vec == 0 && gate_lo == 6'h3F)); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(ka) && $stable(kb) && $stable(sector) && $stable(vec) && $stable(gate_hi))); // R2
  AST_KA_RANGE: assert property (@(posedge clk) disable iff (rst) (ka >= -3 && ka <= 3)); // R3
  AST_KA_ONE_STEP: assert property (@(posedge clk) disable iff (rst) en |=> (ka - $past(ka) <= 1 && $past(ka) - ka <= 1)); // R4
  AST_KB_RANGE: assert property (@(posedge clk) disable iff (rst) (kb >= -2 && kb <= 2)); // R5
  AST_KB_ONE_STEP: assert property (@(posedge clk) disable iff (rst) en |=> (kb - $past(kb) <= 1 && $past(kb) - kb <= 1)); // R5
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (rst) sector <= 3'd5); // R6
  AST_CENTER_ZERO: assert property (@(posedge clk) disable iff (rst) (ka == 0 && kb == 0) |-> vec == 0); // R7
  AST_GATE_COMPL: assert property (@(posedge clk) disable iff (rst) (gate_lo == ~gate_hi && gate_hi == vec)); // R9
endmodule

bind svsel_hyst svsel_hyst_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ka(ka), .kb(kb), .sector(sector),
  .vec(vec), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/svsel_hyst_bench.sv
module svsel_hyst_bench;
  localparam int EW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [EW-1:0] err_a = '0, err_b = '0;
  logic [2:0] isgn = 3'b100;
  logic vc_hi_gt = 1'b1;
  logic [EW-1:0] thr_a1 = 16'd100, thr_a2 = 16'd200, thr_a3 = 16'd300;
  logic [EW-1:0] thr_b1 = 16'd100, thr_b2 = 16'd200, hyst = 16'd20;
  logic signed [2:0] ka, kb;
  logic [2:0] sector;
  logic [5:0] vec, gate_hi, gate_lo;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  svsel_hyst #(.EW(EW)) u_svsel_hyst (
    .clk(clk), .rst(rst), .en(en), .err_a(err_a), .err_b(err_b), .isgn(isgn),
    .vc_hi_gt(vc_hi_gt), .thr_a1(thr_a1), .thr_a2(thr_a2), .thr_a3(thr_a3),
    .thr_b1(thr_b1), .thr_b2(thr_b2), .hyst(hyst), .ka(ka), .kb(kb),
    .sector(sector), .vec(vec), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic strobe(input int ea, input int eb, input logic [2:0] s, input logic gt);
    @(negedge clk);
    err_a = EW'(ea); err_b = EW'(eb); isgn = s; vc_hi_gt = gt; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ka", int'(ka), 0);
    chk("R1 kb", int'(kb), 0);
    chk("R1 sector", int'(sector), 0);
    chk("R1 vec", int'(vec), 0);
    chk("R1 gate_hi", int'(gate_hi), 0);
    chk("R1 gate_lo", int'(gate_lo), 63);
  endtask

  task automatic t_hold();
    do_reset();
    @(negedge clk); err_a = 16'sd1000; err_b = -16'sd1000; isgn = 3'b011;
    repeat (4) @(negedge clk);
    chk("R2 ka held", int'(ka), 0);
    chk("R2 kb held", int'(kb), 0);
    chk("R2 sector held", int'(sector), 0);
    strobe(1000, -1000, 3'b011, 1'b1);
    chk("R2 ka after strobe", int'(ka), 1);
    chk("R2 sector after strobe", int'(sector), 3);
  endtask

  task automatic t_alpha();
    do_reset();
    strobe(1000, 0, 3'b100, 1'b1); chk("R3 ka step1", int'(ka), 1);
    strobe(1000, 0, 3'b100, 1'b1); chk("R3 ka step2", int'(ka), 2);
    strobe(1000, 0, 3'b100, 1'b1); chk("R3 ka step3", int'(ka), 3);
    strobe(1000, 0, 3'b100, 1'b1); chk("R3 ka sat", int'(ka), 3);
    chk("R5 kb idle", int'(kb), 0);
    chk("R8 vec(3,0)", int'(vec), 2);
    chk("R9 gate_hi", int'(gate_hi), 2);
    chk("R9 gate_lo", int'(gate_lo), 61);
    strobe(295, 0, 3'b100, 1'b1); chk("R4 inside band hold", int'(ka), 3);
    strobe(285, 0, 3'b100, 1'b1); chk("R4 below band down", int'(ka), 2);
    strobe(205, 0, 3'b100, 1'b1); chk("R4 mid hold", int'(ka), 2);
    for (int i = 0; i < 6; i++) strobe(-1000, 0, 3'b100, 1'b1);
    chk("R4 ka sat low", int'(ka), -3);
    do_reset();
    strobe(105, 0, 3'b100, 1'b1); chk("R3 under up edge", int'(ka), 0);
    strobe(115, 0, 3'b100, 1'b1); chk("R3 over up edge", int'(ka), 1);
    do_reset();
    strobe(-105, 0, 3'b100, 1'b1); chk("R4 above down edge", int'(ka), 0);
    strobe(-115, 0, 3'b100, 1'b1); chk("R4 below down edge", int'(ka), -1);
  endtask

  task automatic t_beta_corner();
    do_reset();
    strobe(-1000, 1000, 3'b100, 1'b1); chk("R5 kb step1", int'(kb), 1);
    strobe(-1000, 1000, 3'b100, 1'b1); chk("R5 kb step2", int'(kb), 2);
    strobe(-1000, 1000, 3'b100, 1'b1); chk("R5 kb sat", int'(kb), 2);
    chk("R3 ka neg", int'(ka), -3);
    chk("R7 corner upper-high", int'(vec), 27);
    chk("R9 corner gate_hi", int'(gate_hi), 27);
    chk("R9 corner gate_lo", int'(gate_lo), 36);
    strobe(-1000, 1000, 3'b100, 1'b0);
    chk("R7 corner lower-high", int'(vec), 13);
    chk("R9 gate_hi 13", int'(gate_hi), 13);
    do_reset();
    strobe(0, 0, 3'b100, 1'b0); chk("R7 center lo", int'(vec), 0);
    strobe(0, 0, 3'b100, 1'b1); chk("R7 center hi", int'(vec), 0);
  endtask

  task automatic t_sector();
    logic [2:0] codes [8] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101, 3'b000, 3'b111};
    int exp_s [8] = '{0, 1, 2, 3, 4, 5, 5, 5};
    do_reset();
    for (int i = 0; i < 8; i++) begin
      strobe(0, 0, codes[i], 1'b1);
      chk("R6 sector", int'(sector), exp_s[i]);
    end
  endtask

  task automatic t_table();
    do_reset();
    strobe(1000, -1000, 3'b110, 1'b1);
    chk("R8 ka=1", int'(ka), 1);
    chk("R8 kb=-1", int'(kb), -1);
    chk("R8 vec hi", int'(vec), 3);
    strobe(150, -150, 3'b110, 1'b0);
    chk("R8 level held", int'(ka) * 10 + int'(kb), 9);
    chk("R8 vec lo", int'(vec), 31);
    chk("R9 gate_lo 31", int'(gate_lo), 32);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_alpha();
    t_beta_corner();
    t_sector();
    t_table();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule